// File: doc/BRIEF.md
# USB Host Port Suspend and Resume Controller

This block sits on the host side of a full-speed USB port. While the port is suspended, it watches the decoded line state and raises a wake-up flag whenever the bus leaves idle. A K state on the line means that the device is asking to wake the bus. That case raises a second flag of its own, so that software can tell a remote wake-up from noise, a disconnect or an illegal line state.

Software answers a wake-up with a resume command. The block then drives K downstream for a bounded number of millisecond ticks. After that it returns the port to the ready state, with start-of-frame generation enabled. A resume command only takes effect if start-of-frame generation was enabled by an earlier write. Software must issue the resume within 1 ms of seeing an upstream wake-up; the block gives it the flag and the interrupt it needs to meet that limit.

The register port is write-only and has three addresses:
- Control, at address 0: bit 0 is the start-of-frame enable, bit 1 requests suspend, bit 2 requests resume.
- Flag clear, at address 1: write one to clear.
- Interrupt enable, at address 2.

In the flag and enable registers, bit 0 is the wake-up flag and bit 1 is the upstream-resume flag.

Top module: `usbh_rsm_ctrl`

## Requirements
- R1: While suspended, any line state other than J sets the wake-up flag (bit 0). Line state encoding: 2'b00 SE0, 2'b01 J, 2'b10 K, 2'b11 SE1.
- R2: While suspended, a K line state (2'b10) also sets the upstream-resume flag (bit 1). SE0 and SE1 never set bit 1. Holding J sets neither flag.
- R3: While the port is not suspended, non-J line states set no flag.
- R4: A valid resume command drives drive_k high from the clock edge that takes the write. drive_k stays high across exactly RESUME_MS+1 tick_1k pulses, which guarantees at least RESUME_MS ms of K. drive_k drops on the edge that takes the last of those pulses.
- R5: A resume command (control bit 2) has no effect unless the start-of-frame enable was already 1 before that write. A write that sets bit 0 and bit 2 together leaves drive_k low and the port suspended.
- R6: When the resume drive ends, suspended is 0, and port_ready is 1 while the start-of-frame enable is set.
- R7: A write of one to a bit at the flag-clear address clears that flag. If a flag is being set in the same cycle, the set wins.
- R8: irq is the OR of the flags whose enable bit is set. A flag whose enable bit is clear does not drive irq.
- R9: After reset, all flags, enables, the start-of-frame enable, drive_k, suspended, port_ready and irq are 0.
- R10: A resume command written while the port is not suspended is ignored, and drive_k stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Decoded bus line state (SE0/J/K/SE1) |
| tick_1k | input | 1 | One-cycle pulse at 1 kHz |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| sof_en | output | 1 | Start-of-frame generation enable |
| suspended | output | 1 | Port is in suspend |
| drive_k | output | 1 | Drive K state onto the bus |
| port_ready | output | 1 | Port ready with start-of-frame running |
| irq_flags | output | 2 | Wake-up (bit 0) and upstream-resume (bit 1) flags |
| irq | output | 1 | Interrupt request |

## Verification
A port state machine stuck in the wrong state shows up on suspended or drive_k within one cycle of the write that should have moved it. An off-by-one in the resume counter changes the number of tick pulses seen while drive_k is high, so it appears at the end of a single resume. A wrong line-state decode sets the wrong flag pair, and the flags show it two cycles after the line changes. A broken clear or enable path is visible on irq_flags and irq on the cycle after the register write.

// File: rtl/usbh_rsm_pkg.sv
package usbh_rsm_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    PS_READY   = 2'b00,
    PS_SUSPEND = 2'b01,
    PS_RESUME  = 2'b10
  } port_t;

  localparam int NFLAG      = 2;
  localparam int FLAG_WAKE  = 0;
  localparam int FLAG_UPRES = 1;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CLR  = 2'd1;
  localparam logic [1:0] ADDR_EN   = 2'd2;

  localparam int CB_SOF  = 0;
  localparam int CB_SUSP = 1;
  localparam int CB_RSM  = 2;
endpackage

// File: rtl/usbh_rsm_wake.sv
module usbh_rsm_wake
  import usbh_rsm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       suspended,
  input  logic [1:0] line_state,
  output logic       wake_set,
  output logic       upres_set
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_set  <= 1'b0;
      upres_set <= 1'b0;
    end else begin
      wake_set  <= suspended && (line_state != LS_J);
      upres_set <= suspended && (line_state == LS_K);
    end
  end

  AST_UPRES_NEEDS_SUSP: assert property (@(posedge clk) disable iff (rst)
    upres_set |-> $past(suspended)); // R3
endmodule

// File: rtl/usbh_rsm_irq.sv
module usbh_rsm_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic         en_wr,
  input  logic [N-1:0] en_data,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (en_wr) en_q <= en_data;
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr_wr && clr_mask[i]) flags[i] <= 1'b0;
    end

    AST_FLAG_RISE_HAS_SET: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[i]) |-> $past(set[i])); // R1
  end

  assign irq = |(flags & en_q);

  AST_IRQ_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |-> !irq); // R8
endmodule

// File: rtl/usbh_rsm_seq.sv
module usbh_rsm_seq
  import usbh_rsm_pkg::*;
#(
  parameter int RESUME_MS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1k,
  input  logic ctrl_wr,
  input  logic want_susp,
  input  logic want_rsm,
  input  logic sof_en,
  output logic suspended,
  output logic drive_k
);
  localparam int CW = $clog2(RESUME_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(RESUME_MS);

  port_t         state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_READY;
      cnt   <= '0;
    end else begin
      unique case (state)
        PS_READY: if (ctrl_wr && want_susp) state <= PS_SUSPEND;
        PS_SUSPEND: begin
          if (ctrl_wr && want_rsm && sof_en) begin
            state <= PS_RESUME;
            cnt   <= '0;
          end
        end
        PS_RESUME: begin
          if (tick_1k) begin
            if (cnt == LAST) state <= PS_READY;
            else cnt <= cnt + 1'b1;
          end
        end
        default: state <= PS_READY;
      endcase
    end
  end

  assign suspended = (state == PS_SUSPEND);
  assign drive_k   = (state == PS_RESUME);

  AST_RESUME_NEEDS_SOF: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_k) |-> $past(sof_en)); // R5
  AST_DRIVE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_k) |-> $past(tick_1k)); // R4
  AST_READY_AFTER_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_k) |-> !suspended); // R6
endmodule

// File: rtl/usbh_rsm_ctrl.sv
module usbh_rsm_ctrl
  import usbh_rsm_pkg::*;
#(
  parameter int DW        = 8,
  parameter int RESUME_MS = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    line_state,
  input  logic          tick_1k,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          sof_en,
  output logic          suspended,
  output logic          drive_k,
  output logic          port_ready,
  output logic [1:0]    irq_flags,
  output logic          irq
);
  logic ctrl_wr, clr_wr, en_wr;
  logic wake_set, upres_set;
  logic [NFLAG-1:0] set_vec;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign clr_wr  = reg_wr && (reg_addr == ADDR_CLR);
  assign en_wr   = reg_wr && (reg_addr == ADDR_EN);

  always_ff @(posedge clk) begin
    if (rst) sof_en <= 1'b0;
    else if (ctrl_wr) sof_en <= reg_wdata[CB_SOF];
  end

  usbh_rsm_seq #(.RESUME_MS(RESUME_MS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick_1k   (tick_1k),
    .ctrl_wr   (ctrl_wr),
    .want_susp (reg_wdata[CB_SUSP]),
    .want_rsm  (reg_wdata[CB_RSM]),
    .sof_en    (sof_en),
    .suspended (suspended),
    .drive_k   (drive_k)
  );

  usbh_rsm_wake u_wake (
    .clk        (clk),
    .rst        (rst),
    .suspended  (suspended),
    .line_state (line_state),
    .wake_set   (wake_set),
    .upres_set  (upres_set)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[FLAG_WAKE]  = wake_set;
    set_vec[FLAG_UPRES] = upres_set;
  end

  usbh_rsm_irq #(.N(NFLAG)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set      (set_vec),
    .clr_wr   (clr_wr),
    .clr_mask (reg_wdata[NFLAG-1:0]),
    .en_wr    (en_wr),
    .en_data  (reg_wdata[NFLAG-1:0]),
    .flags    (irq_flags),
    .irq      (irq)
  );

  assign port_ready = sof_en && !suspended && !drive_k;

  AST_UPRES_WITH_WAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flags[FLAG_UPRES]) |-> irq_flags[FLAG_WAKE]); // R2
  AST_NO_K_OUTSIDE_RESUME: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_k) |-> $past(suspended)); // R10
endmodule

// File: tb/usbh_rsm_ctrl_bench.sv
module usbh_rsm_ctrl_bench;
  localparam int RMS = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] line_state = 2'b01;
  logic       tick_1k = 1'b0;
  logic       tick_en = 1'b0;
  logic [2:0] div = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       sof_en, suspended, drive_k, port_ready, irq;
  logic [1:0] irq_flags;

  int tests = 0;
  int fails = 0;

  // {line_state, expected flags {upres, wake}}
  localparam logic [3:0] VEC [0:3] = '{4'b01_00, 4'b10_11, 4'b00_01, 4'b11_01};

  always #2 clk = ~clk;

  always @(posedge clk) begin
    div     <= div + 1'b1;
    tick_1k <= tick_en && (div == 3'd7);
  end

  usbh_rsm_ctrl #(.DW(8), .RESUME_MS(RMS)) u_usbh_rsm_ctrl (
    .clk(clk), .rst(rst), .line_state(line_state), .tick_1k(tick_1k),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .sof_en(sof_en), .suspended(suspended), .drive_k(drive_k),
    .port_ready(port_ready), .irq_flags(irq_flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R9 reset state
    chk("R9 flags", {6'd0, irq_flags}, 8'h0);
    chk("R9 outs", {3'd0, sof_en, suspended, drive_k, port_ready, irq}, 8'h0);

    wr(2'd2, 8'h03);
    wr(2'd0, 8'h01);
    chk("R6 ready", {7'd0, port_ready}, 8'h1);

    // R3 non-J while ready
    line_state = 2'b10; idle(4); line_state = 2'b01; idle(3);
    chk("R3 no flag", {6'd0, irq_flags}, 8'h0);

    // R10 resume while ready
    wr(2'd0, 8'h05); idle(2);
    chk("R10 drive_k", {7'd0, drive_k}, 8'h0);

    // suspend, sof off
    wr(2'd0, 8'h02);
    chk("R5 susp", {7'd0, suspended}, 8'h1);

    for (int i = 0; i < 4; i++) begin
      line_state = VEC[i][3:2]; idle(3);
      line_state = 2'b01; idle(3);
      chk("R1/R2 flags", {6'd0, irq_flags}, {6'd0, VEC[i][1:0]});
      chk("R8 irq", {7'd0, irq}, {7'd0, (VEC[i][1:0] != 2'b00)});
      wr(2'd1, 8'h03);
      chk("R7 clear", {6'd0, irq_flags}, 8'h0);
    end

    // R8 masking
    wr(2'd2, 8'h01);
    line_state = 2'b10; idle(3); line_state = 2'b01; idle(3);
    chk("R8 flags", {6'd0, irq_flags}, 8'h3);
    chk("R8 irq on", {7'd0, irq}, 8'h1);
    wr(2'd1, 8'h01);
    chk("R8 masked", {6'd0, irq_flags, 1'b0, irq} & 8'h0f, 8'h08);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h03);

    // R7 set beats clear while K held
    line_state = 2'b10; idle(3);
    wr(2'd1, 8'h03);
    chk("R7 set wins", {6'd0, irq_flags}, 8'h3);
    line_state = 2'b01; idle(3);
    wr(2'd1, 8'h03);
    chk("R7 cleared", {6'd0, irq_flags}, 8'h0);

    // R5 resume without prior sof enable
    wr(2'd0, 8'h06); idle(1);
    chk("R5 ignored", {6'd0, suspended, drive_k}, 8'h2);
    wr(2'd0, 8'h07); idle(1);
    chk("R5 same write", {6'd0, suspended, drive_k}, 8'h2);

    // R4 resume drive
    tick_en = 1'b1;
    wr(2'd0, 8'h05);
    chk("R4 drive on", {7'd0, drive_k}, 8'h1);
    n = 0;
    for (int g = 0; g < 5000 && drive_k; g++) begin
      if (tick_1k) n++;
      @(negedge clk);
    end
    chk("R4 tick count", n[7:0], 8'(RMS + 1));
    chk("R4 drive off", {7'd0, drive_k}, 8'h0);
    chk("R6 after", {6'd0, suspended, port_ready}, 8'h1);
    tick_en = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule